// File: doc/BRIEF.md
# Diagnostic Syndrome Accumulator

A memory self-test engine reports a diagnostic record each time a read returns the wrong data. Each record holds the address of the failing cell and the syndrome of that failure: one bit for each read step of the test algorithm, set where that step failed. A single defective cell usually fails at several read steps, so the raw stream repeats addresses. This block folds those repeats together. It keeps a small content-addressable table. When a record's address is already in the table, its syndrome bits are ORed into that entry. When the address is new, the record takes the next free entry. Each faulty cell therefore leaves the block once, carrying the union of every syndrome bit seen for it.

Entry allocation uses a thermometer register that acts as both the per-entry valid mask and the free-slot pointer. It fills upward as entries are allocated and drains downward as entries are unloaded. After the test, a single unload pulse drains the table one entry per cycle, in allocation order. The table is empty when the drain ends.

Top module: `syn_accum_top`

## Requirements
- R1: Synchronous reset clears every entry's valid state. Reset also drives `hit`, `overflow` and `out_valid` low. An unload started right after reset emits nothing.
- R2: A record whose address matches no valid entry is stored in the lowest-numbered free entry. `hit` is low in the following cycle.
- R3: A record whose address matches a valid entry ORs its syndrome into that entry. `hit` is high for exactly the cycle after that record.
- R4: Entries that are not valid never match, even when their stored address equals the incoming one. For example, address 0 right after reset is a miss.
- R5: When all DEPTH entries are valid, a record that misses is dropped and sets `overflow`. A record that hits while the table is full still merges.
- R6: A one-cycle `unload_go` pulse makes the block present the valid entries on consecutive cycles. Each entry appears as `out_addr`/`out_syn` with `out_valid` high, oldest allocation first, and each appears exactly once.
- R7: When the unload completes, the table is empty. A previously stored address then allocates a fresh entry.
- R8: While an unload is in progress, incoming records and further `unload_go` pulses are ignored. Such a record gives `hit` low and is not stored.
- R9: Records may arrive on consecutive cycles. A record matching the address stored by the previous cycle's record already hits.
- R10: `overflow` stays high once set, through unloads, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid | input | 1 | Diagnostic record present this cycle |
| rec_addr | input | ADDR_W | Faulty-cell address of the record |
| rec_syn | input | SYN_W | Syndrome bits of the record |
| unload_go | input | 1 | Pulse that starts draining the table |
| hit | output | 1 | Previous cycle's record matched a stored entry |
| overflow | output | 1 | Sticky: a new address was dropped because the table was full |
| out_valid | output | 1 | An unloaded entry is on `out_addr`/`out_syn` |
| out_addr | output | ADDR_W | Address of the unloaded entry |
| out_syn | output | SYN_W | Accumulated syndrome of the unloaded entry |

## Verification
The bench aims at address 0 arriving first after reset. A design that matched on stale register contents instead of the valid mask would report a hit there and lose the entry. It sends the same address on back-to-back cycles; a lookup that lags by one cycle would create a duplicate entry that shows up at unload. It fills the table, then checks two things: a further new address sets the sticky overflow flag, and a hit still merges while the table is full. Finally, it injects records and a second start pulse during a drain. A design that accepted them would emit extra or misordered entries, or keep an entry after the drain.

// File: rtl/syn_accum_pkg.sv
package syn_accum_pkg;

    localparam int DEF_ADDR_W = 6;
    localparam int DEF_SYN_W  = 6;
    localparam int DEF_DEPTH  = 8;

    typedef enum logic [0:0] {
        UL_IDLE  = 1'b0,
        UL_DRAIN = 1'b1
    } ul_state_e;

    // Lookup result for one incoming record
    typedef struct packed {
        logic take;   // record accepted (not during unload)
        logic hit;    // matches a valid entry
        logic alloc;  // goes into a new entry
        logic drop;   // miss while table full
    } lookup_t;

    function automatic lookup_t classify(input logic vld, input logic busy,
                                         input logic any_match, input logic full);
        lookup_t r;
        r.take  = vld && !busy;
        r.hit   = r.take && any_match;
        r.alloc = r.take && !any_match && !full;
        r.drop  = r.take && !any_match && full;
        return r;
    endfunction

endpackage

// File: rtl/syn_cam_entry.sv
module syn_cam_entry #(
    parameter int ADDR_W = 6,
    parameter int SYN_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] key_i,
    input  logic [SYN_W-1:0]  syn_i,
    input  logic              load_i,
    input  logic              merge_i,
    input  logic              shift_i,
    input  logic [ADDR_W-1:0] up_addr_i,
    input  logic [SYN_W-1:0]  up_syn_i,
    output logic              match_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [SYN_W-1:0]  syn_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [SYN_W-1:0]  syn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            syn_q  <= '0;
        end else if (shift_i) begin
            addr_q <= up_addr_i;
            syn_q  <= up_syn_i;
        end else if (load_i) begin
            addr_q <= key_i;
            syn_q  <= syn_i;
        end else if (merge_i) begin
            syn_q  <= syn_q | syn_i;
        end
    end

    assign match_o = valid_i && (addr_q == key_i);
    assign addr_o  = addr_q;
    assign syn_o   = syn_q;
endmodule

// File: rtl/syn_alloc_ptr.sv
module syn_alloc_ptr #(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    output logic [DEPTH-1:0] mask_o,
    output logic [DEPTH-1:0] free_oh_o,
    output logic             full_o
);
    logic [DEPTH-1:0] therm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            therm_q <= '0;
        end else if (push_i) begin
            therm_q <= {therm_q[DEPTH-2:0], 1'b1};
        end else if (pop_i) begin
            therm_q <= {1'b0, therm_q[DEPTH-1:1]};
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_free
            if (i == 0) begin : g_lo
                assign free_oh_o[i] = !therm_q[0];
            end else begin : g_hi
                assign free_oh_o[i] = !therm_q[i] && therm_q[i-1];
            end
        end
    endgenerate

    assign mask_o = therm_q;
    assign full_o = therm_q[DEPTH-1];
endmodule

// File: rtl/syn_unload_ctrl.sv
module syn_unload_ctrl
    import syn_accum_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go_i,
    input  logic head_valid_i,
    output logic busy_o,
    output logic pop_o
);
    ul_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= UL_IDLE;
        end else begin
            case (state_q)
                UL_IDLE:  if (go_i) state_q <= UL_DRAIN;
                UL_DRAIN: if (!head_valid_i) state_q <= UL_IDLE;
                default:  state_q <= UL_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q == UL_DRAIN);
    assign pop_o  = busy_o && head_valid_i;
endmodule

// File: rtl/syn_accum_top.sv
module syn_accum_top
    import syn_accum_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int SYN_W  = DEF_SYN_W,
    parameter int DEPTH  = DEF_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rec_valid,
    input  logic [ADDR_W-1:0] rec_addr,
    input  logic [SYN_W-1:0]  rec_syn,
    input  logic              unload_go,
    output logic              hit,
    output logic              overflow,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [SYN_W-1:0]  out_syn
);
    logic [DEPTH-1:0]  ent_mask;
    logic [DEPTH-1:0]  ent_free;
    logic [DEPTH-1:0]  ent_match;
    logic              tbl_full;
    logic              ul_busy;
    logic              ul_pop;
    logic [ADDR_W-1:0] ent_addr [DEPTH];
    logic [SYN_W-1:0]  ent_syn  [DEPTH];
    lookup_t           lk;

    assign lk = classify(rec_valid, ul_busy, |ent_match, tbl_full);

    syn_alloc_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .push_i    (lk.alloc),
        .pop_i     (ul_pop),
        .mask_o    (ent_mask),
        .free_oh_o (ent_free),
        .full_o    (tbl_full)
    );

    syn_unload_ctrl u_ul (
        .clk          (clk),
        .rst          (rst),
        .go_i         (unload_go),
        .head_valid_i (ent_mask[0]),
        .busy_o       (ul_busy),
        .pop_o        (ul_pop)
    );

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            logic [ADDR_W-1:0] up_a;
            logic [SYN_W-1:0]  up_s;
            if (i == DEPTH - 1) begin : g_top
                assign up_a = '0;
                assign up_s = '0;
            end else begin : g_mid
                assign up_a = ent_addr[i+1];
                assign up_s = ent_syn[i+1];
            end
            syn_cam_entry #(.ADDR_W(ADDR_W), .SYN_W(SYN_W)) u_ent (
                .clk       (clk),
                .rst       (rst),
                .valid_i   (ent_mask[i]),
                .key_i     (rec_addr),
                .syn_i     (rec_syn),
                .load_i    (lk.alloc && ent_free[i]),
                .merge_i   (lk.hit && ent_match[i]),
                .shift_i   (ul_pop),
                .up_addr_i (up_a),
                .up_syn_i  (up_s),
                .match_o   (ent_match[i]),
                .addr_o    (ent_addr[i]),
                .syn_o     (ent_syn[i])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hit       <= 1'b0;
            overflow  <= 1'b0;
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_syn   <= '0;
        end else begin
            hit       <= lk.hit;
            out_valid <= ul_pop;
            if (lk.drop) overflow <= 1'b1;
            if (ul_pop) begin
                out_addr <= ent_addr[0];
                out_syn  <= ent_syn[0];
            end
        end
    end
endmodule

// File: rtl/syn_accum_chk.sv
module syn_accum_chk #(
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             hit,
    input logic             overflow,
    input logic             out_valid,
    input logic             busy,
    input logic [DEPTH-1:0] mask
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!hit && !overflow && !out_valid && mask == '0));

    // R2
    mask_therm_chk: assert property (@(posedge clk) disable iff (rst)
        (((mask + 1'b1) & mask) == '0));

    // R3
    hit_no_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (mask == $past(mask)));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(mask[DEPTH-1]));

    // R6
    unload_shift_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (mask == ($past(mask) >> 1)));

    // R8
    busy_no_grow_chk: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> ((mask & ~$past(mask)) == '0));

    // R10
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
endmodule

bind syn_accum_top syn_accum_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hit       (hit),
    .overflow  (overflow),
    .out_valid (out_valid),
    .busy      (ul_busy),
    .mask      (ent_mask)
);

// File: tb/test_syn_accum_top.sv
module test_syn_accum_top;
    localparam int AW = 6;
    localparam int SW = 6;
    localparam int D  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rec_valid = 1'b0;
    logic [AW-1:0] rec_addr = '0;
    logic [SW-1:0] rec_syn = '0;
    logic          unload_go = 1'b0;
    logic          hit, overflow, out_valid;
    logic [AW-1:0] out_addr;
    logic [SW-1:0] out_syn;

    int n_chk = 0;
    int n_fail = 0;

    logic [AW-1:0] m_addr [D];
    logic [SW-1:0] m_syn  [D];
    int            m_cnt = 0;
    logic          m_ovf = 1'b0;
    logic [AW+SW-1:0] expq [$];

    always #10 clk = ~clk;

    syn_accum_top #(.ADDR_W(AW), .SYN_W(SW), .DEPTH(D)) i_syn_accum_top (
        .clk(clk), .rst(rst), .rec_valid(rec_valid), .rec_addr(rec_addr),
        .rec_syn(rec_syn), .unload_go(unload_go), .hit(hit), .overflow(overflow),
        .out_valid(out_valid), .out_addr(out_addr), .out_syn(out_syn)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop expected entries as the design unloads them (R6)
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R6 extra output", {20'd0, out_addr, out_syn}, 0);
            end else begin
                logic [AW+SW-1:0] e;
                e = expq.pop_front();
                check({out_addr, out_syn} == e, "R6 unload order/content",
                      {20'd0, out_addr, out_syn}, {20'd0, e});
            end
        end
    end

    // Driver: one record per call, back-to-back when called in sequence
    task automatic send(input logic [AW-1:0] a, input logic [SW-1:0] s, input string req);
        bit exp_hit = 1'b0;
        for (int i = 0; i < m_cnt; i++) begin
            if (m_addr[i] == a) begin
                exp_hit = 1'b1;
                m_syn[i] = m_syn[i] | s;
            end
        end
        if (!exp_hit) begin
            if (m_cnt < D) begin
                m_addr[m_cnt] = a;
                m_syn[m_cnt]  = s;
                m_cnt++;
            end else begin
                m_ovf = 1'b1;
            end
        end
        rec_valid = 1'b1;
        rec_addr  = a;
        rec_syn   = s;
        @(negedge clk);
        check(hit == exp_hit, req, {31'd0, hit}, {31'd0, exp_hit});
        check(overflow == m_ovf, "R5/R10 overflow", {31'd0, overflow}, {31'd0, m_ovf});
    endtask

    task automatic idle();
        rec_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic unload(input bit noisy);
        rec_valid = 1'b0;
        for (int i = 0; i < m_cnt; i++) expq.push_back({m_addr[i], m_syn[i]});
        unload_go = 1'b1;
        @(negedge clk);
        unload_go = 1'b0;
        if (noisy) begin
            // R8: records and a second start during the drain are ignored
            for (int k = 0; k < 2; k++) begin
                rec_valid = 1'b1;
                rec_addr  = m_addr[m_cnt-1];
                rec_syn   = 6'b111111;
                unload_go = 1'b1;
                @(negedge clk);
                check(hit == 1'b0, "R8 record ignored during unload", {31'd0, hit}, 0);
            end
            rec_valid = 1'b0;
            unload_go = 1'b0;
        end
        m_cnt = 0;
        for (int g = 0; g < 40 && expq.size() > 0; g++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(expq.size() == 0, "R6 all entries unloaded", expq.size(), 0);
        check(out_valid == 1'b0, "R6 out_valid low after drain", {31'd0, out_valid}, 0);
    endtask

    initial begin
        #(20 * 200000);
        check(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(hit == 0 && overflow == 0 && out_valid == 0, "R1 reset outputs",
              {29'd0, hit, overflow, out_valid}, 0);
        unload(1'b0);                          // R1: empty unload emits nothing

        send(6'h00, 6'b000001, "R4 address 0 after reset misses");
        send(6'h2A, 6'b000010, "R2 new address allocates");
        send(6'h2A, 6'b001000, "R9 back-to-back same address hits");
        send(6'h05, 6'b000100, "R2 new address allocates");
        send(6'h00, 6'b100000, "R3 repeat address merges");
        idle();
        send(6'h2A, 6'b010000, "R3 repeat address merges");
        idle();
        unload(1'b0);                          // R6: 00/21, 2A/1A, 05/04

        send(6'h2A, 6'b000001, "R7 table empty after unload");
        for (int i = 1; i <= 7; i++) send(6'(i + 8), 6'(i), "R2 fill table");
        send(6'h3F, 6'b000011, "R5 miss when full dropped");
        send(6'h2A, 6'b100000, "R5 hit merges when full");
        idle();
        unload(1'b1);                          // R8 noise during drain
        send(6'h0F, 6'b000001, "R8 ignored record not stored");
        idle();
        check(overflow == 1'b1, "R10 overflow sticky across unload", {31'd0, overflow}, 1);
        unload(1'b0);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_ovf = 1'b0;
        check(overflow == 1'b0, "R1 reset clears overflow", {31'd0, overflow}, 0);
        send(6'h0F, 6'b000001, "R1 reset empties table");
        idle();
        unload(1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule